// File: doc/BRIEF.md
# Zero-Crossing Phase-Tracking Loop with Delayed Period Control

This block is the core of a first-order zero-crossing digital phase-locked loop. A down-counting period generator issues one-cycle sample strobes to an external converter. The converter answers each strobe with one signed sample, qualified by a valid flag, some clocks later. The sample is held in a capture register until the next strobe. At that strobe it moves into a history register, and a pure-gain loop filter turns it into the output `y`. The period loaded at that strobe is the nominal period minus a correction. The correction is the filter's product for that sample plus a weighted difference between that sample and the one before it.

Each sample therefore steers the interval that starts at the strobe after it arrives: the sampling interval k is set by the sample taken two strobes earlier. This delay gives the arithmetic a full interval to settle before its result is needed. A signed stabilizing weight, normally negative, feeds back the sample-to-sample change. It widens the range of loop gain over which the delayed loop stays locked. The weight is clamped to a bounded magnitude, because large weights destabilise the loop. Gain, weight and nominal period are static inputs in Q-format fixed point with `FRAC` fraction bits. Samples are plain signed integers.

Top module: `zcpll_core`

## Requirements
- R1: While reset is held, `strobe_o`, `period_o`, `y_o` and `overrun_o` are all zero, and the capture and history registers are cleared. At the first clock edge after release, `period_o` loads clamp(`t0_i`) with no correction applied.
- R2: `strobe_o` is a single-cycle pulse. If it is high in cycle c, then `period_o` takes a new value P at the edge closing cycle c, stays stable until the next strobe, and the next strobe is high in cycle c+P. After the initial load, the first strobe appears in the cycle numbered clamp(`t0_i`), counting the cycle after the load as 1.
- R3: The first valid sample after a strobe is captured. Any further valid sample before the next strobe is ignored and does not reach `y_o`. Such a sample also sets `overrun_o` at the following edge, and `overrun_o` then stays high until reset.
- R4: At the edge closing a strobe cycle, `y_o` becomes sat(rnd(`g1_i`·x)), where x is the captured sample (0 if none arrived). rnd(v) = floor((v + 2^(FRAC−1)) / 2^FRAC). sat limits the result to the signed `CNT_W`-bit range.
- R5: At the same edge, `period_o` becomes clamp(`t0_i` − sat(rnd(`g1_i`·x + b·(x − xp)))). Here xp is the sample transferred at the previous strobe (0 after reset), so a sample sets the interval after the one in which it arrives.
- R6: With `b_i` = 0 the period follows `t0_i` − sat(rnd(`g1_i`·x)) exactly, the plain delayed loop.
- R7: The weight b is `b_i` limited to the range −`B_LIM`..+`B_LIM` before use.
- R8: Every loaded period is limited to `P_MIN`..`P_MAX`, so the interval never collapses or wraps.
- R9: A valid sample in the strobe cycle itself is captured as the sample of the new interval. It causes no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t0_i | input | CNT_W | Nominal period in clocks, unsigned |
| g1_i | input | COEF_W | Loop gain, signed, FRAC fraction bits |
| b_i | input | COEF_W | Stabilizing weight, signed, FRAC fraction bits |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_i | input | SMP_W | Signed sample from the converter |
| strobe_o | output | 1 | Sample strobe, one cycle |
| period_o | output | CNT_W | Period of the interval now running |
| y_o | output | CNT_W | Filter output of the last transferred sample, signed |
| overrun_o | output | 1 | Sticky flag: sample arrived while the capture register was full |

## Verification
`strobe_o` is combinational from the counter, so it is compared during the cycle it is high. `period_o`, `y_o` and the history register change at the edge that closes the strobe cycle, so they are compared at the falling edge one cycle later. `overrun_o` is compared one edge after the offending valid. A sample driven in interval k is first visible in `y_o` and `period_o` after strobe k+1, and the bench's model applies it there. All outputs are sampled on falling edges, away from the edge that updates them.

// File: rtl/zcpll_pkg.sv
package zcpll_pkg;
  localparam int ACC_W = 48;
  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic acc_t clamp_acc(acc_t v, acc_t lo, acc_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // round half up, then drop frac bits
  function automatic acc_t round_shift(acc_t v, int unsigned frac);
    return (v + (acc_t'(1) <<< (frac - 1))) >>> frac;
  endfunction
endpackage

// File: rtl/zcpll_dco.sv
module zcpll_dco
  import zcpll_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int P_MIN = 8,
  parameter int P_MAX = 65535
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        t0_i,
  input  logic signed [CNT_W-1:0] corr_i,
  output logic                    strobe_o,
  output logic [CNT_W-1:0]        period_o
);
  localparam int PAD_W = ACC_W - CNT_W;

  logic [CNT_W-1:0] cnt_q, per_q, nxt;
  logic start, expire;
  acc_t t0_w, corr_w;

  assign start  = (cnt_q == '0);
  assign expire = (cnt_q == CNT_W'(1));
  assign t0_w   = $signed({{PAD_W{1'b0}}, t0_i});
  assign corr_w = start ? '0 : $signed({{PAD_W{corr_i[CNT_W-1]}}, corr_i});
  assign nxt    = CNT_W'(clamp_acc(t0_w - corr_w, acc_t'(P_MIN), acc_t'(P_MAX)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (start || expire) begin
      cnt_q <= nxt;
      per_q <= nxt;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign strobe_o = expire;
  assign period_o = per_q;

  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  // R2
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_o && cnt_q != '0) |=> $stable(period_o));
  // R8
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (period_o >= CNT_W'(P_MIN) && period_o <= CNT_W'(P_MAX)));
endmodule

// File: rtl/zcpll_smp_pipe.sv
module zcpll_smp_pipe #(
  parameter int SMP_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    strobe_i,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] smp_i,
  output logic signed [SMP_W-1:0] x_new_o,
  output logic signed [SMP_W-1:0] x_prev_o,
  output logic                    overrun_o
);
  logic signed [SMP_W-1:0] cap_q, hist_q;
  logic full_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      full_q <= 1'b0;
      hist_q <= '0;
      ovr_q  <= 1'b0;
    end else if (strobe_i) begin
      hist_q <= cap_q;
      cap_q  <= valid_i ? smp_i : '0;
      full_q <= valid_i;
    end else if (valid_i) begin
      if (!full_q) begin
        cap_q  <= smp_i;
        full_q <= 1'b1;
      end else begin
        ovr_q <= 1'b1;
      end
    end
  end

  assign x_new_o   = cap_q;
  assign x_prev_o  = hist_q;
  assign overrun_o = ovr_q;

  // R3
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  // R3
  overrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(valid_i && full_q && !strobe_i));
  // R3
  cap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !valid_i) |=> (cap_q == '0 && !full_q));
endmodule

// File: rtl/zcpll_gain.sv
module zcpll_gain
  import zcpll_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int COEF_W  = 16,
  parameter int CNT_W   = 16,
  parameter int FRAC    = 12,
  parameter int B_LIM   = 8192,
  parameter bit STAB_EN = 1'b1
) (
  input  logic signed [COEF_W-1:0] g1_i,
  input  logic signed [COEF_W-1:0] b_i,
  input  logic signed [SMP_W-1:0]  x_new_i,
  input  logic signed [SMP_W-1:0]  x_prev_i,
  output logic signed [CNT_W-1:0]  y_o,
  output logic signed [CNT_W-1:0]  corr_o
);
  localparam acc_t OUT_MAX = (acc_t'(1) <<< (CNT_W - 1)) - acc_t'(1);
  localparam acc_t OUT_MIN = -(acc_t'(1) <<< (CNT_W - 1));

  acc_t py, ps;

  assign py = acc_t'(g1_i) * acc_t'(x_new_i);

  generate
    if (STAB_EN) begin : g_stab
      acc_t b_w, d_w;
      assign b_w = clamp_acc(acc_t'(b_i), -acc_t'(B_LIM), acc_t'(B_LIM));
      assign d_w = acc_t'(x_new_i) - acc_t'(x_prev_i);
      assign ps  = b_w * d_w;
    end else begin : g_plain
      assign ps = '0;
    end
  endgenerate

  assign y_o    = CNT_W'(clamp_acc(round_shift(py, FRAC), OUT_MIN, OUT_MAX));
  assign corr_o = CNT_W'(clamp_acc(round_shift(py + ps, FRAC), OUT_MIN, OUT_MAX));
endmodule

// File: rtl/zcpll_core.sv
module zcpll_core #(
  parameter int CNT_W   = 16,
  parameter int SMP_W   = 12,
  parameter int COEF_W  = 16,
  parameter int FRAC    = 12,
  parameter int P_MIN   = 8,
  parameter int P_MAX   = 65535,
  parameter int B_LIM   = 8192,
  parameter bit STAB_EN = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CNT_W-1:0]         t0_i,
  input  logic signed [COEF_W-1:0] g1_i,
  input  logic signed [COEF_W-1:0] b_i,
  input  logic                     smp_valid_i,
  input  logic signed [SMP_W-1:0]  smp_i,
  output logic                     strobe_o,
  output logic [CNT_W-1:0]         period_o,
  output logic signed [CNT_W-1:0]  y_o,
  output logic                     overrun_o
);
  logic strobe;
  logic signed [SMP_W-1:0] x_new, x_prev;
  logic signed [CNT_W-1:0] y_nxt, corr;
  logic signed [CNT_W-1:0] y_q;

  zcpll_dco #(.CNT_W(CNT_W), .P_MIN(P_MIN), .P_MAX(P_MAX)) u_dco (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .t0_i     (t0_i),
    .corr_i   (corr),
    .strobe_o (strobe),
    .period_o (period_o)
  );

  zcpll_smp_pipe #(.SMP_W(SMP_W)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe),
    .valid_i   (smp_valid_i),
    .smp_i     (smp_i),
    .x_new_o   (x_new),
    .x_prev_o  (x_prev),
    .overrun_o (overrun_o)
  );

  zcpll_gain #(
    .SMP_W(SMP_W), .COEF_W(COEF_W), .CNT_W(CNT_W), .FRAC(FRAC),
    .B_LIM(B_LIM), .STAB_EN(STAB_EN)
  ) u_gain (
    .g1_i     (g1_i),
    .b_i      (b_i),
    .x_new_i  (x_new),
    .x_prev_i (x_prev),
    .y_o      (y_nxt),
    .corr_o   (corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_q <= '0;
    else if (strobe) y_q <= y_nxt;
  end

  assign strobe_o = strobe;
  assign y_o      = y_q;

  // R4
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |=> $stable(y_o));
endmodule

// File: tb/zcpll_core_test.sv
module zcpll_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 12;
  localparam int SMP_W  = 12;
  localparam int COEF_W = 16;
  localparam int FRAC   = 12;
  localparam int P_MIN  = 8;
  localparam int P_MAX  = 200;
  localparam int B_LIM  = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] t0_r = 12'd40;
  logic signed [COEF_W-1:0] g1_r = '0;
  logic signed [COEF_W-1:0] b_r = '0;
  logic vld_r = 1'b0;
  logic signed [SMP_W-1:0] smp_r = '0;
  logic strobe;
  logic [CNT_W-1:0] period;
  logic signed [CNT_W-1:0] y;
  logic ovr;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcpll_core #(
    .CNT_W(CNT_W), .SMP_W(SMP_W), .COEF_W(COEF_W), .FRAC(FRAC),
    .P_MIN(P_MIN), .P_MAX(P_MAX), .B_LIM(B_LIM), .STAB_EN(1'b1)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .t0_i(t0_r), .g1_i(g1_r), .b_i(b_r),
    .smp_valid_i(vld_r), .smp_i(smp_r),
    .strobe_o(strobe), .period_o(period), .y_o(y), .overrun_o(ovr)
  );

  // reference model state
  longint m_cnt = 0, m_per = 0, m_cap = 0, m_xa = 0, m_y = 0;
  bit m_full = 0, m_ovr = 0;

  function automatic longint clampl(longint v, longint lo, longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic longint rnd_sat(longint p);
    longint r;
    r = (p + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    return clampl(r, -(64'sd1 <<< (CNT_W - 1)), (64'sd1 <<< (CNT_W - 1)) - 1);
  endfunction

  function automatic longint corr_f(longint x, longint xp);
    longint bw;
    bw = clampl(longint'(b_r), -B_LIM, B_LIM);
    return rnd_sat(longint'(g1_r) * x + bw * (x - xp));
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  int since = 0;
  int dly = 2;
  bit skip = 0;

  // one clock cycle: drive, compare, advance model; entered and left at negedge
  task automatic step(string ptag, int amp, bit extra);
    bit sm, v;
    longint s, c, nxt;
    sm = (m_cnt == 1);
    v = 0;
    s = 0;
    if (sm && extra && ($urandom % 2 == 0)) v = 1;       // R9 strobe-cycle sample
    if (!sm && since == dly && !skip) v = 1;
    if (!sm && extra && since == dly + 2) v = 1;         // R3 second sample
    if (v) s = longint'($urandom % (2 * amp + 1)) - amp;
    vld_r = v;
    smp_r = SMP_W'(s);

    chk("R2", "strobe", longint'(strobe), longint'(sm));
    chk(ptag, "period", longint'(period), m_per);
    chk((ptag == "R9") ? "R3" : "R4", "y", longint'(y), m_y);
    chk("R3", "overrun", longint'(ovr), longint'(m_ovr));

    if (m_cnt == 0 || sm) begin
      c = (m_cnt == 0) ? 0 : corr_f(m_cap, m_xa);
      nxt = clampl(longint'(t0_r) - c, P_MIN, P_MAX);
      m_cnt = nxt;
      m_per = nxt;
    end else begin
      m_cnt--;
    end
    if (sm) begin
      m_y = rnd_sat(longint'(g1_r) * m_cap);
      m_xa = m_cap;
      m_cap = v ? s : 0;
      m_full = v;
    end else if (v) begin
      if (!m_full) begin
        m_cap = s;
        m_full = 1;
      end else begin
        m_ovr = 1;
      end
    end

    if (sm) begin
      since = 0;
      dly = 1 + int'($urandom % 4);
      skip = ($urandom % 8 == 0);
    end else begin
      since++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_phase(string ptag, int amp, bit extra, int nstrobes);
    int seen = 0;
    while (seen < nstrobes) begin
      if (m_cnt == 1) seen++;
      step(ptag, amp, extra);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    g1_r = 16'sd2048;
    b_r = '0;
    repeat (3) @(negedge clk);
    chk("R1", "strobe in reset", longint'(strobe), 0);
    chk("R1", "period in reset", longint'(period), 0);
    chk("R1", "y in reset", longint'(y), 0);
    chk("R1", "overrun in reset", longint'(ovr), 0);
    rst_n = 1'b1;
    // first edge: load of clamp(t0) with no correction
    step("R1", 100, 0);
    chk("R1", "initial period", longint'(period), 40);
    run_phase("R6", 100, 0, 25);                  // b = 0
    g1_r = 16'sd2048; b_r = -16'sd1638;           // gain 0.5, weight -0.4
    run_phase("R5", 100, 0, 25);
    b_r = -16'sd20000;                            // beyond -B_LIM
    run_phase("R7", 300, 0, 25);
    b_r = 16'sd20000;
    run_phase("R7", 300, 0, 10);
    g1_r = 16'sh7FFF; b_r = -16'sd4096;           // drives both period limits
    run_phase("R8", 2047, 0, 30);
    g1_r = 16'sd2048; b_r = -16'sd1638;
    run_phase("R9", 100, 1, 30);                  // extra and strobe-cycle samples
    chk("R3", "overrun latched", longint'(ovr), 1);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule